// File: doc/BRIEF.md
# Serial Scan-Chain Debug Port

This block is the target-side end of a three-wire debug link: serial clock, host-to-target data, and target-to-host data, with no select line. A host uses it to read a small processor's visible registers and to push an instruction into that processor. All link inputs and the processor step clock are asynchronous to the system clock. The block synchronises them and detects their rising edges in the system clock domain.

Each processor step arms the port. The next serial clock rising edge then copies a 64-bit register snapshot into the shift chain in one parallel load, and shifts nothing. After that, every serial clock rising edge shifts the chain by one bit, MSB first. The outgoing bit is presented on `miso_o`, and a bit from `mosi_i` is taken in at the bottom of the chain. When 64 bits have been shifted in, the received frame is latched. The port then presents its top byte as a command code and its low 16 bits as an instruction word. It raises a force request when the command code marks a host command.

The snapshot is ordered from the top byte down as: control, R0, R1, R2, R3, PC, IR high, IR low. The snapshot source supplies it already in that order.

Top module: `scan_dbg_port`

## Requirements
- R1: After reset, `miso_o`, `frame_valid_o` and `force_o` are 0, and `cmd_o` and `instr_o` read 0.
- R2: The first `sclk_i` rising edge after a rising edge of `step_i` loads `snap_i` in parallel and shifts nothing. `miso_o` then shows `snap_i[63]` before the next rising edge, whatever `mosi_i` holds.
- R3: Each later `sclk_i` rising edge shifts the chain by one bit. After k shifts, `miso_o` shows snapshot bit 63-k, so the host reads the snapshot MSB first.
- R4: `mosi_i` is sampled on each shifting `sclk_i` rising edge, and the first bit received ends up as frame bit 63. When the frame is complete, `cmd_o` is frame bits 63:56 and `instr_o` is frame bits 15:0.
- R5: `frame_valid_o` rises with the 64th shift. It stays high, with `cmd_o` and `instr_o` unchanged, until the next parallel load, which clears it.
- R6: `force_o` is 1 exactly when `frame_valid_o` is 1 and `cmd_o` equals 0x02.
- R7: An all-zero frame gives `frame_valid_o` = 1 with `force_o` = 0 and `instr_o` = 0, so it requests nothing of the processor.
- R8: `sclk_i` rising edges after the 64th shift and before the next step change neither `miso_o`, `cmd_o`, `instr_o` nor `frame_valid_o`.
- R9: `sclk_i` rising edges after reset and before the first step are ignored: `miso_o` stays 0 and `frame_valid_o` stays 0.
- R10: A step that arrives partway through a frame discards the partial frame. The next `sclk_i` rising edge reloads the chain from `snap_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| mosi_i | input | 1 | Serial data from host, asynchronous |
| step_i | input | 1 | Processor step clock, asynchronous |
| snap_i | input | 64 | Register snapshot to capture on load |
| miso_o | output | 1 | Serial data to host, chain MSB |
| frame_valid_o | output | 1 | Received frame complete and held |
| cmd_o | output | 8 | Command byte of the held frame |
| instr_o | output | 16 | Instruction word of the held frame |
| force_o | output | 1 | Request to force `instr_o` into the IR |

## Verification
Each edge on `sclk_i` or `step_i` passes through two synchroniser flops and an edge flop, so its effect reaches the outputs at the third rising edge of `clk_i` after the edge is driven. The bench holds every serial clock level and every step level for four system clocks. It reads `miso_o` at the end of each low phase, which is exactly where the host samples, and it checks the frame outputs only after a whole level period has passed. That way every check lands at least one cycle after the result is due. Results that should hold, such as the outputs under the ignored edges of R8 and R9, are read after those edges have had the same settling time.

// File: rtl/scan_dbg_pkg.sv
package scan_dbg_pkg;
  localparam int unsigned FRAME_W   = 64;
  localparam int unsigned CMD_W     = 8;
  localparam int unsigned INSTR_W   = 16;
  localparam int unsigned CNT_W     = $clog2(FRAME_W + 1);
  localparam logic [CMD_W-1:0] CMD_FORCE = 8'h02;
endpackage

// File: rtl/scan_dbg_sync.sv
module scan_dbg_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
    assign rise_o[g] = sync_q[g] & ~prev_q[g];
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/scan_dbg_chain.sv
module scan_dbg_chain
  import scan_dbg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_rise_i,
  input  logic               step_rise_i,
  input  logic               mosi_i,
  input  logic [FRAME_W-1:0] snap_i,
  output logic               load_o,
  output logic               idle_o,
  output logic               miso_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_valid_o
);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg_q, frame_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               armed_q, valid_q;
  logic [FRAME_W-1:0] shifted;

  assign shifted = {shreg_q[FRAME_W-2:0], mosi_i};
  assign load_o  = sclk_rise_i & armed_q;
  assign idle_o  = ~armed_q & (cnt_q == CNT_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      frame_q <= '0;
      cnt_q   <= CNT_DONE;   // idle until the first load
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (step_rise_i) armed_q <= 1'b1;
      if (sclk_rise_i) begin
        if (armed_q) begin
          shreg_q <= snap_i;
          cnt_q   <= '0;
          valid_q <= 1'b0;
          armed_q <= step_rise_i;
        end else if (cnt_q != CNT_DONE) begin
          shreg_q <= shifted;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            frame_q <= shifted;
            valid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign miso_o        = shreg_q[FRAME_W-1];
  assign frame_o       = frame_q;
  assign frame_valid_o = valid_q;
endmodule

// File: rtl/scan_dbg_decode.sv
module scan_dbg_decode
  import scan_dbg_pkg::*;
(
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               valid_i,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic               force_o
);
  assign cmd_o   = frame_i[FRAME_W-1 -: CMD_W];
  assign instr_o = frame_i[INSTR_W-1:0];
  assign force_o = valid_i & (cmd_o == CMD_FORCE);
endmodule

// File: rtl/scan_dbg_port.sv
module scan_dbg_port
  import scan_dbg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                mosi_i,
  input  logic                step_i,
  input  logic [63:0]         snap_i,
  output logic                miso_o,
  output logic                frame_valid_o,
  output logic [7:0]          cmd_o,
  output logic [15:0]         instr_o,
  output logic                force_o
);
  localparam int unsigned N_SYNC = 3;

  logic [N_SYNC-1:0] sync_v, rise_v;
  logic              sclk_rise, step_rise, mosi_s;
  logic              load_evt, idle;
  logic [FRAME_W-1:0] frame;

  scan_dbg_sync #(.W(N_SYNC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({step_i, mosi_i, sclk_i}),
    .sync_o  (sync_v),
    .rise_o  (rise_v)
  );

  assign sclk_rise = rise_v[0];
  assign mosi_s    = sync_v[1];
  assign step_rise = rise_v[2];

  scan_dbg_chain u_chain (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sclk_rise_i   (sclk_rise),
    .step_rise_i   (step_rise),
    .mosi_i        (mosi_s),
    .snap_i        (snap_i),
    .load_o        (load_evt),
    .idle_o        (idle),
    .miso_o        (miso_o),
    .frame_o       (frame),
    .frame_valid_o (frame_valid_o)
  );

  scan_dbg_decode u_dec (
    .frame_i (frame),
    .valid_i (frame_valid_o),
    .cmd_o   (cmd_o),
    .instr_o (instr_o),
    .force_o (force_o)
  );
endmodule

// File: rtl/scan_dbg_checker.sv
module scan_dbg_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        load_evt,
  input logic        sclk_rise,
  input logic        idle,
  input logic        snap_msb,
  input logic        miso_o,
  input logic        frame_valid_o,
  input logic [7:0]  cmd_o,
  input logic [15:0] instr_o,
  input logic        force_o
);
  AST_LOAD_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt |=> miso_o == $past(snap_msb)); // R2

  AST_LOAD_CLEARS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt |=> !frame_valid_o); // R5

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o && !load_evt |=> frame_valid_o); // R5

  AST_FRAME_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o && !load_evt |=> $stable(cmd_o) && $stable(instr_o)); // R5

  AST_FORCE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_o |-> frame_valid_o && cmd_o == 8'h02); // R6

  AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise && idle |=> $stable(miso_o) && $stable(frame_valid_o)); // R8
endmodule

bind scan_dbg_port scan_dbg_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .load_evt      (load_evt),
  .sclk_rise     (sclk_rise),
  .idle          (idle),
  .snap_msb      (snap_i[63]),
  .miso_o        (miso_o),
  .frame_valid_o (frame_valid_o),
  .cmd_o         (cmd_o),
  .instr_o       (instr_o),
  .force_o       (force_o)
);

// File: tb/tb_scan_dbg_port.sv
module tb_scan_dbg_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0, mosi_i = 1'b0, step_i = 1'b0;
  logic [63:0] snap_i = '0;
  logic        miso_o, frame_valid_o, force_o;
  logic [7:0]  cmd_o;
  logic [15:0] instr_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  scan_dbg_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk_i), .mosi_i(mosi_i),
    .step_i(step_i), .snap_i(snap_i), .miso_o(miso_o),
    .frame_valid_o(frame_valid_o), .cmd_o(cmd_o), .instr_o(instr_o),
    .force_o(force_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (4) @(negedge clk);
  endtask

  task automatic step_pulse();
    step_i = 1'b1; hold();
    step_i = 1'b0; hold();
  endtask

  // one serial bit: drive mosi low phase, sample miso at end of low, then rise
  task automatic bit_xfer(input logic b, output logic rx);
    mosi_i = b; hold();
    rx = miso_o;
    sclk_i = 1'b1; hold();
    sclk_i = 1'b0;
  endtask

  task automatic load_pulse();
    mosi_i = 1'b1;
    hold();
    sclk_i = 1'b1; hold();
    sclk_i = 1'b0; hold();
  endtask

  task automatic run_frame(input logic [63:0] snap, input logic [63:0] tx,
                           output logic [63:0] rx);
    step_pulse();
    snap_i = snap;
    load_pulse();
    chk("R2 miso after load", 64'(miso_o), 64'(snap[63]));
    chk("R5 valid cleared by load", 64'(frame_valid_o), 64'd0);
    for (int i = 63; i >= 0; i--) begin
      logic r;
      bit_xfer(tx[i], r);
      rx[i] = r;
    end
    hold();
  endtask

  task automatic t_reset();
    chk("R1 miso", 64'(miso_o), 64'd0);
    chk("R1 valid", 64'(frame_valid_o), 64'd0);
    chk("R1 force", 64'(force_o), 64'd0);
    chk("R1 cmd/instr", {40'd0, cmd_o, instr_o}, 64'd0);
  endtask

  task automatic t_idle_before_step();
    logic r;
    snap_i = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < 5; i++) bit_xfer(1'b1, r);
    hold();
    chk("R9 miso ignored", 64'(miso_o), 64'd0);
    chk("R9 valid ignored", 64'(frame_valid_o), 64'd0);
  endtask

  task automatic t_force_frame();
    logic [63:0] rx;
    logic [63:0] snap = 64'hA5_11_22_33_44_5A_C8_3C;
    logic [63:0] tx   = {8'h02, 40'h0, 16'hBEEF};
    run_frame(snap, tx, rx);
    chk("R3 snapshot readout", rx, snap);
    chk("R4 cmd", 64'(cmd_o), 64'h02);
    chk("R4 instr", 64'(instr_o), 64'hBEEF);
    chk("R5 valid", 64'(frame_valid_o), 64'd1);
    chk("R6 force on 0x02", 64'(force_o), 64'd1);
  endtask

  task automatic t_extra_edges();
    logic r;
    logic m0 = miso_o;
    for (int i = 0; i < 6; i++) bit_xfer(i[0], r);
    hold();
    chk("R8 miso held", 64'(miso_o), 64'(m0));
    chk("R8 cmd/instr held", {40'd0, cmd_o, instr_o}, {40'd0, 8'h02, 16'hBEEF});
    chk("R8 valid held", 64'(frame_valid_o), 64'd1);
  endtask

  task automatic t_zero_frame();
    logic [63:0] rx;
    logic [63:0] snap = 64'h0123_4567_89AB_CDEF;
    run_frame(snap, 64'd0, rx);
    chk("R3 second readout", rx, snap);
    chk("R7 valid", 64'(frame_valid_o), 64'd1);
    chk("R7 no force", 64'(force_o), 64'd0);
    chk("R7 instr zero", 64'(instr_o), 64'd0);
  endtask

  task automatic t_abort();
    logic [63:0] rx;
    logic r;
    logic [63:0] snap1 = 64'hFFFF_0000_FFFF_0000;
    logic [63:0] snap2 = 64'h7E00_0000_0000_0081;
    logic [63:0] tx    = {8'h13, 40'hFF_FFFF_FFFF, 16'h1234};
    step_pulse();
    snap_i = snap1;
    load_pulse();
    for (int i = 0; i < 20; i++) bit_xfer(1'b1, r);
    run_frame(snap2, tx, rx);
    chk("R10 reload readout", rx, snap2);
    chk("R10 instr", 64'(instr_o), 64'h1234);
    chk("R6 cmd 0x13", 64'(cmd_o), 64'h13);
    chk("R6 no force on 0x13", 64'(force_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    hold();
    t_reset();
    t_idle_before_step();
    t_force_frame();
    t_extra_edges();
    t_zero_frame();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule